// File: doc/BRIEF.md
# Checkpointed Future Register File

This block holds the register state of an in-order-issue pipeline whose instructions may finish out of order. It keeps two copies of the registers. The speculative copy feeds decode and takes a result as soon as the instruction finishes. The committed copy changes only when an instruction retires. Each register in the speculative copy carries a pending bit and the sequence tag of the most recent decoded instruction that writes it. A finishing result lands only if its tag matches that last writer.

A small ring of branch snapshots allows fast recovery. When a branch is decoded, the speculative copy is saved into the next free snapshot slot. Results from instructions older than that branch keep flowing into the saved copy. When a branch turns out to be mispredicted, its snapshot replaces the speculative copy in one cycle, and that snapshot plus every younger one is released. An exception instead reloads the speculative copy from the committed copy and releases every snapshot.

Top module: `spec_regfile_ckpt`

## Requirements
- R1: After reset every register reads data 0 with ready 1, `br_ready_o` is 1 and `br_id_o` is 0.
- R2: A decode with a destination sets that register's ready to 0 from the next cycle, and records `dec_seq_i` as its last-writer tag.
- R3: A completion whose tag equals the register's last-writer tag makes the data readable with ready 1 in the next cycle.
- R4: A completion whose tag differs from the register's last-writer tag leaves the speculative register unchanged.
- R5: A retirement writes only the committed copy. The speculative copy does not change.
- R6: On `exc_i`, the next cycle shows the committed contents in every register, including a retirement made in the same cycle. Every register is ready, and every snapshot is free with `br_id_o` set to 0. Any decode, completion or branch allocation in that cycle is dropped.
- R7: A branch allocation with `br_ready_o` high saves the speculative state, including same-cycle decode and completion effects, into slot `br_id_o`. Slots are handed out in ring order 0,1,2,3,0.
- R8: `br_ready_o` is 0 while the slot at the ring position is busy. An allocation request made then changes nothing.
- R9: A completion with a matching tag also updates every snapshot whose branch is younger than the completing instruction.
- R10: A mispredicted resolution of a busy slot loads that slot's snapshot into the speculative copy for the next cycle. It frees that slot and all younger slots, and sets `br_id_o` to the resolved slot.
- R11: A correctly predicted resolution frees only the resolved slot.
- R12: Sequence numbers are 4 bits and wrap modulo 16. Value a is younger than value b when (a-b) mod 16 lies in 1..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| rd_addr_i | input | NRP*AW | decode read register numbers, port p at bits p*AW |
| rd_data_o | output | NRP*DW | speculative values of the read registers |
| rd_ready_o | output | NRP | 1 when the read register has no pending writer |
| dec_valid_i | input | 1 | decoded instruction writes a register |
| dec_rd_i | input | AW | its destination |
| dec_seq_i | input | SW | its sequence number |
| cmp_valid_i | input | 1 | an instruction completes |
| cmp_rd_i | input | AW | completing destination |
| cmp_seq_i | input | SW | completing sequence number |
| cmp_data_i | input | DW | completing result |
| ret_valid_i | input | 1 | an instruction retires |
| ret_rd_i | input | AW | retiring destination |
| ret_data_i | input | DW | retiring result |
| br_alloc_i | input | 1 | a branch is decoded and requests a snapshot |
| br_seq_i | input | SW | the branch's sequence number |
| br_ready_o | output | 1 | a snapshot slot is free at the ring position |
| br_id_o | output | CW | slot that the next allocation takes |
| res_valid_i | input | 1 | a branch resolves |
| res_mispredict_i | input | 1 | the resolving branch was mispredicted |
| res_id_i | input | CW | slot of the resolving branch |
| exc_i | input | 1 | exception: reload from the committed copy |

## Verification
The completion path is tested three ways. One completion matches the last writer. Another carries a stale tag from an older writer of the same register. A third goes to a register held in a snapshot while the live copy has a newer writer. Together these separate updates of the live copy from updates of the snapshot.

Recovery is tested three ways. A mispredict on an older slot must also free a younger one. A correct resolution must free a single slot in a full ring. A pair of branches whose sequence numbers straddle the wrap point tests that age ordering works modulo 16. An exception issued together with a retirement, a decode and an allocation tests the committed-copy reload and the dropping of those same-cycle actions.

// File: rtl/cfrf_pkg.sv
package cfrf_pkg;
  localparam int unsigned NREG  = 8;
  localparam int unsigned DW    = 16;
  localparam int unsigned WIN   = 8;
  localparam int unsigned NCKPT = 4;
  localparam int unsigned NRP   = 2;
  localparam int unsigned AW    = $clog2(NREG);
  localparam int unsigned SW    = $clog2(WIN) + 1;
  localparam int unsigned CW    = $clog2(NCKPT);

  typedef logic [DW-1:0] data_t;
  typedef logic [AW-1:0] reg_t;
  typedef logic [SW-1:0] seq_t;
  typedef logic [CW-1:0] cid_t;

  typedef struct packed {
    logic  pend;
    seq_t  tag;
    data_t data;
  } ent_t;

  typedef ent_t [NREG-1:0] file_t;

  // a younger than b on the wrapping sequence ring
  function automatic logic is_younger(seq_t a, seq_t b);
    seq_t d;
    d = a - b;
    return (d != '0) && !d[SW-1];
  endfunction
endpackage

// File: rtl/cfrf_arch.sv
module cfrf_arch
  import cfrf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ret_valid_i,
  input  reg_t                 ret_rd_i,
  input  data_t                ret_data_i,
  output data_t [NREG-1:0]     arch_nxt_o,
  output data_t [NREG-1:0]     arch_q_o
);
  data_t [NREG-1:0] arch_q;

  always_comb begin
    arch_nxt_o = arch_q;
    if (ret_valid_i) arch_nxt_o[ret_rd_i] = ret_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arch_q <= '0;
    else         arch_q <= arch_nxt_o;
  end

  assign arch_q_o = arch_q;
endmodule

// File: rtl/cfrf_slot.sv
module cfrf_slot
  import cfrf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  snap_i,
  input  file_t snap_file_i,
  input  seq_t  snap_seq_i,
  input  logic  cmp_valid_i,
  input  reg_t  cmp_rd_i,
  input  seq_t  cmp_seq_i,
  input  data_t cmp_data_i,
  output file_t file_o,
  output seq_t  bseq_o
);
  file_t file_q;
  seq_t  bseq_q;

  // older producers keep filling the snapshot
  always_comb begin
    file_o = file_q;
    if (cmp_valid_i && is_younger(bseq_q, cmp_seq_i) &&
        file_q[cmp_rd_i].pend && file_q[cmp_rd_i].tag == cmp_seq_i) begin
      file_o[cmp_rd_i].data = cmp_data_i;
      file_o[cmp_rd_i].pend = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      file_q <= '0;
      bseq_q <= '0;
    end else if (snap_i) begin
      file_q <= snap_file_i;
      bseq_q <= snap_seq_i;
    end else begin
      file_q <= file_o;
    end
  end

  assign bseq_o = bseq_q;
endmodule

// File: rtl/cfrf_ckpt_ctrl.sv
module cfrf_ckpt_ctrl
  import cfrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              exc_i,
  input  logic              res_valid_i,
  input  logic              res_mis_i,
  input  cid_t              res_id_i,
  input  seq_t [NCKPT-1:0]  bseq_i,
  output logic [NCKPT-1:0]  snap_o,
  output logic [NCKPT-1:0]  vld_o,
  output logic              restore_o,
  output logic              ready_o,
  output cid_t              tail_o
);
  logic [NCKPT-1:0] vld_q, vld_d;
  cid_t             tail_q, tail_d;

  assign restore_o = res_valid_i && res_mis_i && vld_q[res_id_i] && !exc_i;
  assign ready_o   = !vld_q[tail_q];

  always_comb begin
    vld_d  = vld_q;
    tail_d = tail_q;
    snap_o = '0;
    if (exc_i) begin
      vld_d  = '0;
      tail_d = '0;
    end else if (restore_o) begin
      for (int j = 0; j < int'(NCKPT); j++)
        if (cid_t'(j) == res_id_i || is_younger(bseq_i[j], bseq_i[res_id_i]))
          vld_d[j] = 1'b0;
      tail_d = res_id_i;
    end else begin
      if (res_valid_i && !res_mis_i) vld_d[res_id_i] = 1'b0;
      if (alloc_i && !vld_q[tail_q]) begin
        snap_o[tail_q] = 1'b1;
        vld_d[tail_q]  = 1'b1;
        tail_d = (tail_q == cid_t'(NCKPT-1)) ? '0 : tail_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      tail_q <= '0;
    end else begin
      vld_q  <= vld_d;
      tail_q <= tail_d;
    end
  end

  assign vld_o  = vld_q;
  assign tail_o = tail_q;
endmodule

// File: rtl/spec_regfile_ckpt.sv
module spec_regfile_ckpt
  import cfrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NRP*AW-1:0] rd_addr_i,
  output logic [NRP*DW-1:0] rd_data_o,
  output logic [NRP-1:0]    rd_ready_o,
  input  logic              dec_valid_i,
  input  logic [AW-1:0]     dec_rd_i,
  input  logic [SW-1:0]     dec_seq_i,
  input  logic              cmp_valid_i,
  input  logic [AW-1:0]     cmp_rd_i,
  input  logic [SW-1:0]     cmp_seq_i,
  input  logic [DW-1:0]     cmp_data_i,
  input  logic              ret_valid_i,
  input  logic [AW-1:0]     ret_rd_i,
  input  logic [DW-1:0]     ret_data_i,
  input  logic              br_alloc_i,
  input  logic [SW-1:0]     br_seq_i,
  output logic              br_ready_o,
  output logic [CW-1:0]     br_id_o,
  input  logic              res_valid_i,
  input  logic              res_mispredict_i,
  input  logic [CW-1:0]     res_id_i,
  input  logic              exc_i
);
  file_t             ff_q, ff_norm, ff_d;
  data_t [NREG-1:0]  arch_nxt, arch_q;
  file_t             slot_file [NCKPT];
  seq_t [NCKPT-1:0]  slot_seq;
  logic [NCKPT-1:0]  snap, ckpt_vld;
  logic              restore;

  cfrf_arch u_arch (
    .clk_i, .rst_ni, .ret_valid_i, .ret_rd_i, .ret_data_i,
    .arch_nxt_o(arch_nxt), .arch_q_o(arch_q)
  );

  cfrf_ckpt_ctrl u_ctrl (
    .clk_i, .rst_ni, .alloc_i(br_alloc_i), .exc_i,
    .res_valid_i, .res_mis_i(res_mispredict_i), .res_id_i,
    .bseq_i(slot_seq), .snap_o(snap), .vld_o(ckpt_vld),
    .restore_o(restore), .ready_o(br_ready_o), .tail_o(br_id_o)
  );

  for (genvar i = 0; i < int'(NCKPT); i++) begin : g_slot
    cfrf_slot u_slot (
      .clk_i, .rst_ni, .snap_i(snap[i]), .snap_file_i(ff_norm),
      .snap_seq_i(br_seq_i), .cmp_valid_i, .cmp_rd_i, .cmp_seq_i,
      .cmp_data_i, .file_o(slot_file[i]), .bseq_o(slot_seq[i])
    );
  end

  always_comb begin
    ff_norm = ff_q;
    if (cmp_valid_i && ff_q[cmp_rd_i].pend && ff_q[cmp_rd_i].tag == cmp_seq_i) begin
      ff_norm[cmp_rd_i].data = cmp_data_i;
      ff_norm[cmp_rd_i].pend = 1'b0;
    end
    if (dec_valid_i) begin
      ff_norm[dec_rd_i].pend = 1'b1;
      ff_norm[dec_rd_i].tag  = dec_seq_i;
    end
  end

  always_comb begin
    if (exc_i) begin
      for (int i = 0; i < int'(NREG); i++) begin
        ff_d[i].pend = 1'b0;
        ff_d[i].tag  = '0;
        ff_d[i].data = arch_nxt[i];
      end
    end else if (restore) begin
      ff_d = slot_file[res_id_i];
    end else begin
      ff_d = ff_norm;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= ff_d;
  end

  for (genvar p = 0; p < int'(NRP); p++) begin : g_rd
    assign rd_data_o[p*DW +: DW] = ff_q[rd_addr_i[p*AW +: AW]].data;
    assign rd_ready_o[p]         = !ff_q[rd_addr_i[p*AW +: AW]].pend;
  end
endmodule

// File: rtl/cfrf_sva.sv
module cfrf_sva
  import cfrf_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             exc_i,
  input logic             restore,
  input cid_t             res_id_i,
  input cid_t             br_id_o,
  input logic             br_alloc_i,
  input logic             br_ready_o,
  input logic [NCKPT-1:0] ckpt_vld,
  input logic [NRP-1:0]   rd_ready_o,
  input logic             ret_valid_i,
  input reg_t             ret_rd_i,
  input data_t            ret_data_i,
  input data_t [NREG-1:0] arch_q,
  input logic             cmp_valid_i,
  input reg_t             cmp_rd_i,
  input seq_t             cmp_seq_i,
  input logic             dec_valid_i,
  input file_t            ff_q
);
  p_exc_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> &rd_ready_o);

  p_exc_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> ckpt_vld == '0);

  p_full_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_alloc_i && !br_ready_o && !exc_i |=>
      $countones(ckpt_vld) <= $past($countones(ckpt_vld)));

  p_stale_cmp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && !exc_i && !restore && !dec_valid_i &&
    ff_q[cmp_rd_i].tag != cmp_seq_i |=>
      ff_q[$past(cmp_rd_i)] == $past(ff_q[cmp_rd_i]));

  p_retire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i |=> arch_q[$past(ret_rd_i)] == $past(ret_data_i));

  p_restore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore |=> !ckpt_vld[$past(res_id_i)] && br_id_o == $past(res_id_i));
endmodule

bind spec_regfile_ckpt cfrf_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .exc_i(exc_i), .restore(restore),
  .res_id_i(res_id_i), .br_id_o(br_id_o), .br_alloc_i(br_alloc_i),
  .br_ready_o(br_ready_o), .ckpt_vld(ckpt_vld), .rd_ready_o(rd_ready_o),
  .ret_valid_i(ret_valid_i), .ret_rd_i(ret_rd_i), .ret_data_i(ret_data_i),
  .arch_q(arch_q), .cmp_valid_i(cmp_valid_i), .cmp_rd_i(cmp_rd_i),
  .cmp_seq_i(cmp_seq_i), .dec_valid_i(dec_valid_i), .ff_q(ff_q)
);

// File: tb/sim_spec_regfile_ckpt.sv
module sim_spec_regfile_ckpt;
  import cfrf_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [NRP*AW-1:0] rd_addr_i = '0;
  logic [NRP*DW-1:0] rd_data_o;
  logic [NRP-1:0]    rd_ready_o;
  logic dec_valid_i, cmp_valid_i, ret_valid_i, br_alloc_i;
  logic res_valid_i, res_mispredict_i, exc_i, br_ready_o;
  logic [AW-1:0] dec_rd_i, cmp_rd_i, ret_rd_i;
  logic [SW-1:0] dec_seq_i, cmp_seq_i, br_seq_i;
  logic [DW-1:0] cmp_data_i, ret_data_i;
  logic [CW-1:0] br_id_o, res_id_i;

  spec_regfile_ckpt u0 (
    .clk_i(clk), .rst_ni, .rd_addr_i, .rd_data_o, .rd_ready_o,
    .dec_valid_i, .dec_rd_i, .dec_seq_i, .cmp_valid_i, .cmp_rd_i,
    .cmp_seq_i, .cmp_data_i, .ret_valid_i, .ret_rd_i, .ret_data_i,
    .br_alloc_i, .br_seq_i, .br_ready_o, .br_id_o, .res_valid_i,
    .res_mispredict_i, .res_id_i, .exc_i
  );

  int total = 0;
  int fails = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    dec_valid_i = 0; dec_rd_i = '0; dec_seq_i = '0;
    cmp_valid_i = 0; cmp_rd_i = '0; cmp_seq_i = '0; cmp_data_i = '0;
    ret_valid_i = 0; ret_rd_i = '0; ret_data_i = '0;
    br_alloc_i = 0; br_seq_i = '0;
    res_valid_i = 0; res_mispredict_i = 0; res_id_i = '0;
    exc_i = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic rd(int p, int r, logic [DW-1:0] d, logic rdy, string tag);
    rd_addr_i[p*AW +: AW] = AW'(r);
    #1;
    chk({tag, " data"}, 32'(rd_data_o[p*DW +: DW]), 32'(d));
    chk({tag, " ready"}, 32'(rd_ready_o[p]), 32'(rdy));
  endtask

  task automatic dec(int r, int s);
    dec_valid_i = 1; dec_rd_i = AW'(r); dec_seq_i = SW'(s); cyc();
  endtask
  task automatic cmp(int r, int s, logic [DW-1:0] d);
    cmp_valid_i = 1; cmp_rd_i = AW'(r); cmp_seq_i = SW'(s); cmp_data_i = d; cyc();
  endtask
  task automatic alloc(int s);
    br_alloc_i = 1; br_seq_i = SW'(s); cyc();
  endtask
  task automatic res(int id, logic mis);
    res_valid_i = 1; res_id_i = CW'(id); res_mispredict_i = mis; cyc();
  endtask
  task automatic br(int id, logic rdy, string tag);
    #1;
    chk({tag, " br_id"}, 32'(br_id_o), 32'(id));
    chk({tag, " br_ready"}, 32'(br_ready_o), 32'(rdy));
  endtask

  task automatic t_reset();
    for (int r = 0; r < int'(NREG); r++) rd(r % 2, r, '0, 1'b1, "R1 reset reg");
    br(0, 1'b1, "R1 reset");
  endtask

  task automatic t_complete();
    dec(1, 1);
    rd(0, 1, '0, 1'b0, "R2 pending after decode");
    cmp(1, 1, 16'h1111);
    rd(1, 1, 16'h1111, 1'b1, "R3 matching completion");
    dec(2, 2);
    dec(2, 3);
    cmp(2, 2, 16'hAAAA);
    rd(0, 2, '0, 1'b0, "R4 stale completion");
    cmp(2, 3, 16'hBBBB);
    rd(0, 2, 16'hBBBB, 1'b1, "R3 newest writer completion");
  endtask

  task automatic t_retire_exc();
    ret_valid_i = 1; ret_rd_i = AW'(5); ret_data_i = 16'h5555; cyc();
    rd(0, 5, '0, 1'b1, "R5 retire leaves future copy");
    dec(3, 4);
    exc_i = 1;
    ret_valid_i = 1; ret_rd_i = AW'(6); ret_data_i = 16'h6666;
    br_alloc_i = 1; br_seq_i = SW'(5);
    dec_valid_i = 1; dec_rd_i = AW'(1); dec_seq_i = SW'(5);
    cyc();
    rd(0, 5, 16'h5555, 1'b1, "R5 retired value after exception");
    rd(1, 6, 16'h6666, 1'b1, "R6 same-cycle retirement");
    rd(0, 3, '0, 1'b1, "R6 pending cleared");
    rd(1, 1, '0, 1'b1, "R6 decode dropped");
    rd(0, 2, '0, 1'b1, "R6 speculative value discarded");
    br(0, 1'b1, "R6 alloc dropped");
  endtask

  task automatic t_ckpt();
    dec(4, 5);
    alloc(6);
    br(1, 1'b1, "R7 first slot");
    dec(4, 7);
    alloc(8);
    br(2, 1'b1, "R7 second slot");
    cmp(4, 7, 16'h7777);
    rd(0, 4, 16'h7777, 1'b1, "R3 live write");
    cmp(4, 5, 16'h5050);
    rd(0, 4, 16'h7777, 1'b1, "R4 older writer ignored by live copy");
    res(0, 1'b1);
    rd(1, 4, 16'h5050, 1'b1, "R9 R10 restored snapshot");
    br(0, 1'b1, "R10 ring rewinds");
    alloc(9);
    alloc(10);
    br(2, 1'b1, "R10 younger slot freed");
    alloc(11);
    br(3, 1'b1, "R7 ring order");
    alloc(12);
    br(0, 1'b0, "R8 ring full");
    alloc(13);
    br(0, 1'b0, "R8 alloc while full ignored");
    res(0, 1'b0);
    br(0, 1'b1, "R11 correct resolve frees slot");
    alloc(13);
    br(1, 1'b0, "R11 other slots kept");
    exc_i = 1; cyc();
    br(0, 1'b1, "R6 exception frees all");
  endtask

  task automatic t_wrap();
    dec(2, 14);
    alloc(15);
    alloc(1);
    dec(2, 2);
    cmp(2, 14, 16'h1414);
    rd(0, 2, '0, 1'b0, "R4 wrap stale tag");
    res(0, 1'b1);
    rd(1, 2, 16'h1414, 1'b1, "R12 snapshot update across wrap");
    br(0, 1'b1, "R12 rewind");
    alloc(3);
    br(1, 1'b1, "R12 wrapped branch counted younger");
  endtask

  initial begin
    #200000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    t_reset();
    t_complete();
    t_retire_exc();
    t_ckpt();
    t_wrap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule